// File: doc/BRIEF.md
# Truncated Booth Mantissa Multiplier

This block produces the 23-bit fraction of a single-precision product in the way a particular console floating-point unit does. That unit is not an exact multiplier. It recodes the multiplier in radix-4 Booth form and throws away the low-order bits of its running sum as it goes. Its result can therefore fall one unit below the round-toward-zero fraction, and it can change when the two operands are swapped.

The caller presents two 32-bit float words and pulses `start`. Only the fraction fields of the two words are used. The block latches them and adds one Booth partial product per clock. It then normalises the sum and returns the fraction together with a one-cycle `done` pulse. Sign, exponent, special values and flags are produced elsewhere, and the caller merges them with this fraction.

Top module: `booth_mant_mul`

## Requirements
- R1: Only bits [22:0] of each operand word are used, each with an implicit leading one that forms a 24-bit significand. Changing bits [31:23] of either word leaves the result unchanged.
- R2: `op_b` is the multiplier. Its significand, shifted left by one, is cut into 13 overlapping 3-bit windows at bit offsets 0, 2, … 24, and window i is recoded against the `op_a` significand S as follows:
  - 000 and 111 give 0.
  - 001 and 010 give +S.
  - 011 gives +2S.
  - 100 gives the 32-bit complement of 2S with a carry bit of 1.
  - 101 and 110 give the 32-bit complement of S with a carry bit of 1.
- R3: For i = 0 to 12 in order, a 64-bit accumulator that starts at zero takes these steps:
  - it adds partial product i, sign-extended from 32 bits and shifted left by 2·i;
  - it then clears its bits [11:0];
  - it then adds carry bit i at bit position 2·i.
- R4: Let V be the accumulator shifted right by 23. If bit 24 of V is set, V is shifted right once more. The result is bits [22:0] of V.
- R5: The result equals the round-toward-zero fraction of the exact significand product, or that value minus one (modulo 2^23).
- R6: The result depends on operand order. Swapping `op_a` and `op_b` can change it, and each order is computed as given.
- R7: A `start` sampled while the block is idle is accepted. `done` is then high for exactly one cycle, in the cycle after the 14th rising edge that follows the accepting edge. A `start` presented in the `done` cycle is accepted.
- R8: While an operation is in progress, `start` and any change of `op_a` or `op_b` have no effect on the operation or its result.
- R9: A synchronous active-high reset drives `done` and `mant` to 0 and abandons any operation in progress without a `done` pulse.
- R10: `mant` holds its last result and changes only at the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation on the current operands |
| op_a | input | 32 | Multiplicand float word (fraction field used) |
| op_b | input | 32 | Multiplier float word (fraction field used) |
| mant | output | 23 | Result fraction, registered |
| done | output | 1 | One-cycle pulse when `mant` holds a new result |

## Verification
The hardest behaviour to reach is the operand-order dependence. A swap changes the result only when the dropped low-order bits push the sum across a fraction boundary, and random pairs rarely do that. The bench therefore runs its behavioural model at time zero over many generated pairs until it finds one whose two orders disagree. It then drives that pair in both orders and requires the two results to differ. Aborting reset, `start` pulses and operand changes during an operation, and back-to-back starts in the `done` cycle are driven as directed sequences.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACC  = 2'd1,
    SEQ_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/booth_window_sel.sv
module booth_window_sel #(
  parameter int NPP   = 13,
  parameter int IDX_W = 4,
  localparam int MULT_W = 2 * NPP + 1
) (
  input  logic [MULT_W-1:0] mult,
  input  logic [IDX_W-1:0]  idx,
  output logic [2:0]        win
);
  logic [2:0] wins [NPP];

  for (genvar g = 0; g < NPP; g++) begin : g_win
    assign wins[g] = mult[2*g+2 : 2*g];
  end

  always_comb begin
    win = 3'b000;
    for (int k = 0; k < NPP; k++) begin
      if (idx == IDX_W'(k)) win = wins[k];
    end
  end
endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
  parameter int SIG_W = 24,
  parameter int PP_W  = 32
) (
  input  logic [2:0]       win,
  input  logic [SIG_W-1:0] sig,
  output logic [PP_W-1:0]  pp,
  output logic             carry
);
  logic [PP_W-1:0] one_x;
  logic [PP_W-1:0] two_x;

  assign one_x = PP_W'(sig);
  assign two_x = PP_W'({sig, 1'b0});

  always_comb begin
    pp    = '0;
    carry = 1'b0;
    unique case (win)
      3'b001, 3'b010: pp = one_x;
      3'b011:         pp = two_x;
      3'b100: begin
        pp    = ~two_x;
        carry = 1'b1;
      end
      3'b101, 3'b110: begin
        pp    = ~one_x;
        carry = 1'b1;
      end
      default: begin
        pp    = '0;
        carry = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/booth_accum.sv
module booth_accum #(
  parameter int ACC_W = 64,
  parameter int PP_W  = 32,
  parameter int CLR_W = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [IDX_W-1:0] idx,
  input  logic [PP_W-1:0]  pp,
  input  logic             carry,
  output logic [ACC_W-1:0] acc_q
);
  localparam logic [ACC_W-1:0] KEEP_MASK = ~((ACC_W'(1) << CLR_W) - ACC_W'(1));

  logic [IDX_W:0]   shamt;
  logic [ACC_W-1:0] pp_ext;
  logic [ACC_W-1:0] pp_sh;
  logic [ACC_W-1:0] summed;
  logic [ACC_W-1:0] trimmed;
  logic [ACC_W-1:0] acc_d;

  assign shamt   = {idx, 1'b0};
  assign pp_ext  = {{(ACC_W-PP_W){pp[PP_W-1]}}, pp};
  assign pp_sh   = pp_ext << shamt;
  assign summed  = acc_q + pp_sh;
  assign trimmed = summed & KEEP_MASK;
  assign acc_d   = trimmed + (ACC_W'(carry) << shamt);

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (step)    acc_q <= acc_d;
  end
endmodule

// File: rtl/mant_norm.sv
module mant_norm #(
  parameter int ACC_W  = 64,
  parameter int FRAC_W = 23
) (
  input  logic [ACC_W-1:0]  acc,
  output logic [FRAC_W-1:0] frac
);
  localparam int TOP = 2 * FRAC_W + 1;

  logic unused_acc_bits;
  assign unused_acc_bits = ^{acc[ACC_W-1:TOP+1], acc[FRAC_W-1:0]};

  assign frac = acc[TOP] ? acc[2*FRAC_W : FRAC_W+1] : acc[2*FRAC_W-1 : FRAC_W];
endmodule

// File: rtl/booth_mant_mul.sv
module booth_mant_mul #(
  parameter int WORD_W = 32,
  parameter int FRAC_W = 23,
  parameter int PP_W   = 32,
  parameter int ACC_W  = 64,
  parameter int CLR_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [FRAC_W-1:0] mant,
  output logic              done
);
  import booth_mul_pkg::*;

  localparam int SIG_W  = FRAC_W + 1;
  localparam int NPP    = (SIG_W + 2) / 2;
  localparam int IDX_W  = $clog2(NPP);
  localparam int MULT_W = 2 * NPP + 1;
  localparam int PAD_W  = MULT_W - SIG_W - 1;

  seq_state_t        state;
  logic [IDX_W-1:0]  step_idx;
  logic [SIG_W-1:0]  sig_s;
  logic [MULT_W-1:0] mult_q;
  logic [2:0]        win;
  logic [PP_W-1:0]   pp;
  logic              pp_carry;
  logic [ACC_W-1:0]  acc_q;
  logic [FRAC_W-1:0] frac_n;
  logic              accept;
  logic              st_acc;
  logic              st_fin;
  logic [CLR_W-1:0]  acc_low;
  logic              unused_hi_bits;

  assign unused_hi_bits = ^{op_a[WORD_W-1:FRAC_W], op_b[WORD_W-1:FRAC_W]};
  assign accept  = (state == SEQ_IDLE) && start;
  assign st_acc  = (state == SEQ_ACC);
  assign st_fin  = (state == SEQ_FIN);
  assign acc_low = acc_q[CLR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      step_idx <= '0;
      sig_s    <= '0;
      mult_q   <= '0;
      mant     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            sig_s    <= {1'b1, op_a[FRAC_W-1:0]};
            mult_q   <= {{PAD_W{1'b0}}, 1'b1, op_b[FRAC_W-1:0], 1'b0};
            step_idx <= '0;
            state    <= SEQ_ACC;
          end
        end
        SEQ_ACC: begin
          if (step_idx == IDX_W'(NPP - 1)) state <= SEQ_FIN;
          else                             step_idx <= step_idx + 1'b1;
        end
        SEQ_FIN: begin
          mant  <= frac_n;
          done  <= 1'b1;
          state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  booth_window_sel #(.NPP(NPP), .IDX_W(IDX_W)) u_win (
    .mult (mult_q),
    .idx  (step_idx),
    .win  (win)
  );

  booth_pp_gen #(.SIG_W(SIG_W), .PP_W(PP_W)) u_pp (
    .win   (win),
    .sig   (sig_s),
    .pp    (pp),
    .carry (pp_carry)
  );

  booth_accum #(.ACC_W(ACC_W), .PP_W(PP_W), .CLR_W(CLR_W), .IDX_W(IDX_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .step  (st_acc),
    .idx   (step_idx),
    .pp    (pp),
    .carry (pp_carry),
    .acc_q (acc_q)
  );

  mant_norm #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_norm (
    .acc  (acc_q),
    .frac (frac_n)
  );
endmodule

// File: rtl/booth_mant_mul_chk.sv
module booth_mant_mul_chk #(
  parameter int FRAC_W = 23,
  parameter int CLR_W  = 12,
  parameter int NPP    = 13,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic [FRAC_W-1:0] mant,
  input logic              st_acc,
  input logic              st_fin,
  input logic [IDX_W-1:0]  step_idx,
  input logic [CLR_W-1:0]  acc_low
);
  localparam int LOW_IDX = CLR_W / 2;

  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (!st_acc && !st_fin && start) |=> (st_acc && step_idx == '0));

  p_fin_done_r7: assert property (@(posedge clk) disable iff (rst)
    st_fin |=> done);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
    (st_acc && start && step_idx != IDX_W'(NPP - 1)) |=>
      (st_acc && step_idx == $past(step_idx) + 1'b1));

  p_low_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (st_acc && step_idx >= IDX_W'(LOW_IDX)) |=> (acc_low == '0));

  p_hold_mant_r10: assert property (@(posedge clk) disable iff (rst)
    !st_fin |=> $stable(mant));
endmodule

bind booth_mant_mul booth_mant_mul_chk #(
  .FRAC_W (FRAC_W),
  .CLR_W  (CLR_W),
  .NPP    (NPP),
  .IDX_W  (IDX_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .done     (done),
  .mant     (mant),
  .st_acc   (st_acc),
  .st_fin   (st_fin),
  .step_idx (step_idx),
  .acc_low  (acc_low)
);

// File: tb/sim_booth_mant_mul.sv
module sim_booth_mant_mul;
  localparam int LAT = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [22:0] mant;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int          m_cnt  = 0;
  logic        m_done = 1'b0;
  logic [22:0] m_mant = '0;
  logic [22:0] m_pend = '0;

  always #5 clk = ~clk;

  booth_mant_mul u0 (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .op_a  (op_a),
    .op_b  (op_b),
    .mant  (mant),
    .done  (done)
  );

  function automatic logic [22:0] ref_booth(input logic [31:0] a, input logic [31:0] b);
    longint s, t, res, part;
    int w, cb;
    logic [31:0] m;
    s = longint'({1'b1, a[22:0]});
    t = longint'({1'b1, b[22:0], 1'b0});
    res = 0;
    for (int i = 0; i < 13; i++) begin
      w = int'((t >> (2 * i)) & 7);
      cb = 0;
      case (w)
        1, 2: part = s;
        3: part = 2 * s;
        4: begin part = -(2 * s) - 1; cb = 1; end
        5, 6: begin part = -s - 1; cb = 1; end
        default: part = 0;
      endcase
      res = res + (part <<< (2 * i));
      res = res & -64'sd4096;
      res = res + (longint'(cb) <<< (2 * i));
    end
    m = 32'(res >>> 23);
    if (m[24]) m = m >> 1;
    return m[22:0];
  endfunction

  function automatic logic [22:0] ref_rz(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    p = 64'({1'b1, a[22:0]}) * 64'({1'b1, b[22:0]});
    return p[47] ? p[46:24] : p[45:23];
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-accurate model, updated on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_done = 1'b0; m_mant = '0;
    end else begin
      m_done = 1'b0;
      if (m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin m_done = 1'b1; m_mant = m_pend; end
      end else if (start) begin
        m_cnt  = LAT;
        m_pend = ref_booth(op_a, op_b);
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    chk(done === m_done, "R7 R8 done pulse", 32'(done), 32'(m_done));
    chk(mant === m_mant, "R10 R3 R4 mant", 32'(mant), 32'(m_mant));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic do_op(input logic [31:0] a, input logic [31:0] b, output logic [22:0] res);
    logic [22:0] rz, d;
    while (m_cnt != 0) @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    res = '0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) begin res = mant; break; end
    end
    chk(res == ref_booth(a, b), "R2 R3 R4 result", 32'(res), 32'(ref_booth(a, b)));
    rz = ref_rz(a, b);
    d  = rz - res;
    chk(d <= 23'd1, "R5 bound vs truncation", 32'(res), 32'(rz));
  endtask

  initial begin
    logic [22:0] r1, r2;
    logic [31:0] sa, sb, pa, pb;
    bit found;

    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mant == '0, "R9 reset state", {8'h0, mant}, 32'h0);
    rst = 1'b0;

    // R2: patterns that reach every window code
    do_op(32'h3f800000, 32'h3f800000, r1);
    chk(r1 == 23'h0, "R4 one times one", 32'(r1), 32'h0);
    do_op(32'h3fffffff, 32'h3fffffff, r1);
    do_op(32'h00555555, 32'h002aaaaa, r1);
    do_op(32'h002aaaaa, 32'h00555555, r1);
    do_op(32'h00400000, 32'h007fffff, r1);
    do_op(32'h00123456, 32'h00333333, r1);
    do_op(32'h00666666, 32'h00199999, r1);

    // R1: upper nine bits have no effect
    do_op(32'h3f123456, 32'h40654321, r1);
    do_op(32'hc0923456, 32'h7fe54321, r2);
    chk(r1 == r2, "R1 upper bits ignored", 32'(r2), 32'(r1));

    // random pairs, back-to-back (start in the done cycle)
    sa = 32'h1234abcd;
    for (int n = 0; n < 150; n++) begin
      sa = xs(sa); sb = xs(sa); sa = sb;
      do_op(xs(sa ^ 32'h5a5a5a5a), sb, r1);
    end

    // R6: find an order-sensitive pair with the model, then drive both orders
    found = 1'b0;
    pa = 32'h0badf00d;
    pb = 32'h0;
    for (int n = 0; n < 50000 && !found; n++) begin
      pa = xs(pa); pb = xs(pa ^ 32'h3c3c3c3c);
      if (ref_booth(pa, pb) != ref_booth(pb, pa)) found = 1'b1;
    end
    if (found) begin
      do_op(pa, pb, r1);
      do_op(pb, pa, r2);
      chk(r1 != r2, "R6 order changes result", 32'(r2), 32'(~r1));
    end

    // R8: start and operand changes while busy
    while (m_cnt != 0) @(negedge clk);
    start = 1'b1; op_a = 32'h00715171; op_b = 32'h00282828;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      start = k[0]; op_a = xs(op_a); op_b = xs(op_b);
    end
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(mant == ref_booth(32'h00715171, 32'h00282828), "R8 busy inputs ignored",
        32'(mant), 32'(ref_booth(32'h00715171, 32'h00282828)));

    // R9: reset aborts an operation in flight
    @(negedge clk);
    start = 1'b1; op_a = 32'h00456789; op_b = 32'h00765432;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(!done, "R9 no done after abort", 32'(done), 32'h0);
    end
    chk(mant == '0, "R9 mant cleared", 32'(mant), 32'h0);

    do_op(32'h00456789, 32'h00765432, r1);
    repeat (3) @(negedge clk);
    chk(mant == r1, "R10 mant held", 32'(mant), 32'(r1));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule